// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sits in the always-on slow clock domain and decides when the rest of the chip is powered. Software arms a shutdown by writing a 1 to the power-down register; the block then drops its power-enable output and waits. It watches an active-low external wakeup pin. Each pin transition passes through a two-flop synchronizer. The pin must stay asserted for a programmed number of consecutive slow-clock ticks before the wakeup is taken, so short glitches are rejected.

Once a wakeup is taken, power-enable goes high again while the system reset output stays low for a second programmed tick count. Reset is then released and the block returns to normal running. Both tick counts are held in 32-bit registers of which only the upper field bits are kept, so every count is a multiple of 32 ticks. With a 32 kHz slow clock the filter spans up to about 2 s and the reset hold up to about 125 ms.

The state machine has four states. RUN has power on and reset released. HIBERNATE has power off and reset low, and it waits for the pin. FILTER has power off and reset low, and it counts pin assertion. RESET_HOLD has power on and reset low, and it counts the hold time. The transitions are:
- Power-down request: RUN to HIBERNATE.
- Pin seen asserted: HIBERNATE to FILTER, or straight to RESET_HOLD when the filter count is 0.
- Pin released: FILTER to HIBERNATE.
- Filter met: FILTER to RESET_HOLD.
- Hold elapsed: RESET_HOLD to RUN.

Top module: `hib_seq`

## Requirements
- R1: After reset, power_en is 1 and sys_rst_n is 1. The filter and hold registers read 0.
- R2: In RUN, a write to offset 0x20 with data bit 0 = 1 makes power_en low from the next cycle. A write there with bit 0 = 0 leaves power_en high. Offset 0x20 reads as 0.
- R3: The filter register at offset 0x24 keeps only bits 15:5. All other bits read 0 whatever was written; for example, writing 0xFFFFFFFF reads back 0x0000FFE0.
- R4: The hold register at offset 0x28 keeps only bits 11:5. All other bits read 0; for example, writing 0xFFFFFFFF reads back 0x00000FE0.
- R5: The wakeup pin is active low and passes through two synchronizer flops. A low level present before clock edge n is first acted on at edge n+2.
- R6: In HIBERNATE or FILTER, wakeup is taken at the edge where the synchronized pin has been seen asserted on F consecutive edges. F is the filter register value. power_en is 1 from that edge on.
- R7: If the synchronized pin deasserts in FILTER, the block returns to HIBERNATE with power still off. The next assertion restarts the count from zero.
- R8: With a filter value of 0, wakeup is taken on the first edge that sees the synchronized pin asserted.
- R9: After wakeup, power_en is 1 and sys_rst_n is 0 for exactly H cycles, where H is the hold register value. Then sys_rst_n goes to 1 (RUN).
- R10: With a hold value of 0, sys_rst_n goes high on the cycle after power_en returns, so reset is low for one cycle.
- R11: A write of 1 to offset 0x20 outside RUN has no effect on the sequence. In particular, it is not remembered after RESET_HOLD ends.
- R12: sys_rst_n is 0 whenever power_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wake_n_pin | input | 1 | External wakeup pin, active low, asynchronous |
| power_en | output | 1 | Power switch enable for the switchable domain |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The bench builds the block with its default field positions: bits 15:5 for the filter, bits 11:5 for the hold, and two synchronizer stages. That way the register masks and the two-edge pin latency are the ones the requirements state. It programs small multiples of 32 ticks, plus zero, for both counts. This lets several complete hibernate and wake cycles fit in a short run, including glitches cut off part way through filtering and the zero-count corner cases. The full-scale field values are covered only through read-back, since running them would take tens of thousands of ticks each.

// File: rtl/hib_seq_pkg.sv
package hib_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HIB  = 2'd1,
        ST_FILT = 2'd2,
        ST_HOLD = 2'd3
    } hib_state_e;

endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RESET_VAL;
                    else        chain_q[i] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RESET_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hib_regs.sv
module hib_regs #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter logic [7:0]  OFS_HIB  = 8'h20,
    parameter logic [7:0]  OFS_FILT = 8'h24,
    parameter logic [7:0]  OFS_HOLD = 8'h28,
    parameter int          FILT_LO  = 5,
    parameter int          FILT_HI  = 15,
    parameter int          HOLD_LO  = 5,
    parameter int          HOLD_HI  = 11,
    parameter int          CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              hib_req,
    output logic [CNT_W-1:0]  filt_ticks,
    output logic [CNT_W-1:0]  hold_ticks
);
    localparam int FILT_W = FILT_HI - FILT_LO + 1;
    localparam int HOLD_W = HOLD_HI - HOLD_LO + 1;

    logic [FILT_W-1:0] filt_q;
    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '0;
            hold_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_FILT)) filt_q <= bus_wdata[FILT_HI:FILT_LO];
            if (bus_addr == ADDR_W'(OFS_HOLD)) hold_q <= bus_wdata[HOLD_HI:HOLD_LO];
        end
    end

    assign hib_req = bus_wr && (bus_addr == ADDR_W'(OFS_HIB)) && bus_wdata[0];

    always_comb begin
        filt_ticks = '0;
        filt_ticks[FILT_HI:FILT_LO] = filt_q;
        hold_ticks = '0;
        hold_ticks[HOLD_HI:HOLD_LO] = hold_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_FILT)) bus_rdata[FILT_HI:FILT_LO] = filt_q;
        else if (bus_addr == ADDR_W'(OFS_HOLD)) bus_rdata[HOLD_HI:HOLD_LO] = hold_q;
    end

    // R3 / R4: stored counts never carry bits below the field
    a_r3_filt_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        filt_ticks[FILT_LO-1:0] == '0);
    a_r4_hold_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ticks[HOLD_LO-1:0] == '0);

endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
    import hib_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hib_req,
    input  logic             wake_sync,
    input  logic [CNT_W-1:0] filt_ticks,
    input  logic [CNT_W-1:0] hold_ticks,
    output logic             power_en,
    output logic             sys_rst_n
);
    localparam logic [CNT_W:0]   ONE_EXT = (CNT_W+1)'(1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

    hib_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             filt_met;
    logic             hold_done;

    assign filt_met  = ({1'b0, cnt_q} + ONE_EXT) >= {1'b0, filt_ticks};
    assign hold_done = cnt_q >= hold_ticks;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (hib_req) begin
                    state_d = ST_HIB;
                    cnt_d   = '0;
                end
            end
            ST_HIB: begin
                if (wake_sync) begin
                    if (filt_ticks < TWO) begin
                        state_d = ST_HOLD;
                    end else begin
                        state_d = ST_FILT;
                    end
                    cnt_d = ONE;
                end
            end
            ST_FILT: begin
                if (!wake_sync) begin
                    state_d = ST_HIB;
                    cnt_d   = '0;
                end else if (filt_met) begin
                    state_d = ST_HOLD;
                    cnt_d   = ONE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_HOLD: begin
                if (hold_done) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        power_en  = 1'b1;
        sys_rst_n = 1'b0;
        unique case (state_q)
            ST_RUN:  sys_rst_n = 1'b1;
            ST_HIB:  power_en  = 1'b0;
            ST_FILT: power_en  = 1'b0;
            ST_HOLD: power_en  = 1'b1;
        endcase
    end

    // R2: a power-down request in RUN removes power next cycle
    a_r2_power_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && hib_req) |=> !power_en);
    // R6: power only returns at an edge that saw the pin asserted
    a_r6_wake_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_en) |-> $past(wake_sync));
    // R7: release during filtering goes back to waiting
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILT && !wake_sync) |=> (state_q == ST_HIB && !power_en));
    // R9: power returns with reset still held low
    a_r9_reset_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_en) |-> !sys_rst_n);
    // R11: a request during the hold does not re-enter hibernation
    a_r11_ignore_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && hib_req) |=> state_q != ST_HIB);
    // R12: reset is low whenever power is off
    a_r12_reset_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !power_en |-> !sys_rst_n);

endmodule

// File: rtl/hib_seq.sv
module hib_seq #(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 32,
    parameter logic [7:0] OFS_HIB     = 8'h20,
    parameter logic [7:0] OFS_FILT    = 8'h24,
    parameter logic [7:0] OFS_HOLD    = 8'h28,
    parameter int         FILT_LO     = 5,
    parameter int         FILT_HI     = 15,
    parameter int         HOLD_LO     = 5,
    parameter int         HOLD_HI     = 11,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_n_pin,
    output logic              power_en,
    output logic              sys_rst_n
);
    localparam int CNT_W = ((FILT_HI > HOLD_HI) ? FILT_HI : HOLD_HI) + 1;

    logic             hib_req;
    logic [CNT_W-1:0] filt_ticks;
    logic [CNT_W-1:0] hold_ticks;
    logic             wake_n_sync;
    logic             wake_sync;

    hib_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_HIB(OFS_HIB), .OFS_FILT(OFS_FILT), .OFS_HOLD(OFS_HOLD),
        .FILT_LO(FILT_LO), .FILT_HI(FILT_HI),
        .HOLD_LO(HOLD_LO), .HOLD_HI(HOLD_HI),
        .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hib_req(hib_req),
        .filt_ticks(filt_ticks), .hold_ticks(hold_ticks)
    );

    hib_sync #(
        .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d(wake_n_pin), .q(wake_n_sync)
    );

    assign wake_sync = !wake_n_sync;

    hib_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .hib_req(hib_req), .wake_sync(wake_sync),
        .filt_ticks(filt_ticks), .hold_ticks(hold_ticks),
        .power_en(power_en), .sys_rst_n(sys_rst_n)
    );

endmodule

// File: tb/hib_seq_test.sv
module hib_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wake_n_pin = 1'b1;
    logic        power_en;
    logic        sys_rst_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hib_seq uut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_n_pin(wake_n_pin),
        .power_en(power_en), .sys_rst_n(sys_rst_n)
    );

    // behavioural reference: 0 run, 1 off-waiting, 2 off-filtering, 3 reset hold
    int m_state = 0;
    int m_seen  = 0;
    int m_held  = 0;
    int m_filt  = 0;
    int m_hold  = 0;
    bit m_p1 = 1, m_p2 = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_seen = 0; m_held = 0; m_filt = 0; m_hold = 0;
            m_p1 = 1; m_p2 = 1;
        end else begin
            automatic bit w = !m_p2;
            automatic int fmin = (m_filt < 1) ? 1 : m_filt;
            automatic int hmin = (m_hold < 1) ? 1 : m_hold;
            case (m_state)
                0: if (bus_wr && bus_addr == 8'h20 && bus_wdata[0]) begin
                       m_state = 1; m_seen = 0;
                   end
                1, 2: begin
                    if (w) begin
                        m_seen++;
                        if (m_seen >= fmin) begin m_state = 3; m_held = 0; end
                        else m_state = 2;
                    end else begin
                        m_seen = 0; m_state = 1;
                    end
                end
                default: begin
                    m_held++;
                    if (m_held >= hmin) m_state = 0;
                end
            endcase
            if (bus_wr && bus_addr == 8'h24) m_filt = int'(bus_wdata & 32'h0000FFE0);
            if (bus_wr && bus_addr == 8'h28) m_hold = int'(bus_wdata & 32'h00000FE0);
            m_p2 = m_p1;
            m_p1 = wake_n_pin;
        end
    end

    // compare with the reference on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic bit exp_p = !(m_state == 1 || m_state == 2);
            automatic bit exp_r = (m_state == 0);
            checks++;
            if (power_en !== exp_p) begin
                errors++;
                $display("FAIL R6/R7 model power_en actual=%0b expected=%0b t=%0t", power_en, exp_p, $time);
            end
            checks++;
            if (sys_rst_n !== exp_r) begin
                errors++;
                $display("FAIL R9/R12 model sys_rst_n actual=%0b expected=%0b t=%0t", sys_rst_n, exp_r, $time);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive pin low now; count edges until power returns, then reset-low cycles
    task automatic wake_and_measure(output int edges, output int low_cycles);
        @(negedge clk);
        wake_n_pin = 1'b0;
        edges = 0;
        while (!power_en && edges < 5000) begin
            @(posedge clk); edges++;
            @(negedge clk);
        end
        low_cycles = 0;
        while (!sys_rst_n && low_cycles < 5000) begin
            low_cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        int e, l;
        idle(3);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 power_en after reset", 32'(power_en), 32'd1);
        check("R1 sys_rst_n after reset", 32'(sys_rst_n), 32'd1);
        rd(8'h24, 32'h0, "R1 filter reset value");
        rd(8'h28, 32'h0, "R1 hold reset value");

        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, 32'h0000_FFE0, "R3 filter mask");
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, 32'h0000_0FE0, "R4 hold mask");
        rd(8'h20, 32'h0, "R2 power-down reg reads 0");
        wr(8'h24, 32'h0000_005F);
        rd(8'h24, 32'h0000_0040, "R3 low bits dropped");
        wr(8'h28, 32'h8000_0020);
        rd(8'h28, 32'h0000_0020, "R4 high bits dropped");

        // write of 0 has no effect
        wr(8'h20, 32'h0000_0000);
        idle(3);
        check("R2 bit0=0 keeps power", 32'(power_en), 32'd1);

        // power down
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R2 power off next cycle", 32'(power_en), 32'd0);
        check("R12 reset low while off", 32'(sys_rst_n), 32'd0);

        // glitch shorter than the filter (64 ticks)
        wake_n_pin = 1'b0; idle(20); wake_n_pin = 1'b1; idle(6);
        check("R7 short glitch keeps power off", 32'(power_en), 32'd0);
        wake_n_pin = 1'b0; idle(50); wake_n_pin = 1'b1; idle(6);
        check("R7 restart after partial filter", 32'(power_en), 32'd0);

        // full wake: 2 sync edges + 64 filter edges; hold 32
        wake_and_measure(e, l);
        check("R5 R6 edges to power return", 32'(e), 32'd66);
        check("R9 reset hold cycles", 32'(l), 32'd32);
        wake_n_pin = 1'b1;
        idle(5);
        check("R9 back in RUN", 32'(sys_rst_n), 32'd1);

        // request during hold is ignored
        wr(8'h20, 32'h1);
        @(negedge clk); wake_n_pin = 1'b0; idle(66);
        check("R11 setup powered", 32'(power_en), 32'd1);
        idle(5);
        wr(8'h20, 32'h1);
        idle(40);
        wake_n_pin = 1'b1;
        idle(10);
        check("R11 no power-down after hold", 32'(power_en), 32'd1);
        check("R11 reset released", 32'(sys_rst_n), 32'd1);

        // zero counts
        wr(8'h24, 32'h0);
        wr(8'h28, 32'h1F);
        rd(8'h28, 32'h0, "R4 sub-field write reads 0");
        wr(8'h20, 32'h1);
        idle(4);
        check("R2 off again", 32'(power_en), 32'd0);
        wake_and_measure(e, l);
        check("R8 zero filter edges", 32'(e), 32'd3);
        check("R10 zero hold one cycle", 32'(l), 32'd1);
        wake_n_pin = 1'b1;
        idle(5);

        // pin held low when power-down is requested: immediate wake path
        wr(8'h24, 32'h20);
        wr(8'h28, 32'h40);
        @(negedge clk); wake_n_pin = 1'b0;
        idle(4);
        wr(8'h20, 32'h1);
        check("R2 off with pin low", 32'(power_en), 32'd0);
        idle(40);
        check("R6 woke after 32 ticks", 32'(power_en), 32'd1);
        wake_n_pin = 1'b1;
        idle(80);
        check("R9 run after 64 hold", 32'(sys_rst_n), 32'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        done = 1;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule